// File: doc/BRIEF.md
# Virtual Interrupt Deactivation Unit

This block services a guest write to the register that deactivates a virtual interrupt. It compares the interrupt ID in the written value against every list register entry in parallel and picks the lowest-index entry whose active bit is set and whose virtual ID is the same. If such an entry exists, the block clears only that entry's active bit. If the entry is backed by a hardware interrupt whose physical ID is below 1020, the block also asks for that physical interrupt to be deactivated. If no entry matches, the block bumps the end-of-interrupt count field in the hypervisor control word.

The block acts only when the guest runs in split priority-drop/deactivate mode and the ID lies inside the supported interrupt range. It passes its results out as registered single-cycle update strobes. The owner of the list registers and the control word applies them, so the block itself stores no architectural state.

List register layout (48 bits): virtual ID in [23:0], physical ID in [33:24], hardware-link flag at bit 34, pending bit at bit 35, active bit at bit 36, and [47:37] reserved (carried through unchanged). Entry i occupies bits [48*i+47:48*i] of the flattened array. The end-of-interrupt count sits in bits [31:27] of the 32-bit control word.

Top module: `vdeact_unit`

## Requirements
- R1: The interrupt ID is `wr_data[23:0]`. Bits [31:24] of the written value have no effect on any output.
- R2: A write whose ID is greater than or equal to `num_irq` produces no list register update, no count update and no physical deactivation.
- R3: A write made while `split_mode` is 0 produces no list register update, no count update and no physical deactivation.
- R4: The selected entry is the lowest index i whose active bit (36) is 1 and whose virtual ID [23:0] equals the written ID. `lr_wr_idx` reports i.
- R5: When no entry matches, `ctrl_wr_en` pulses. `ctrl_wr_data` equals `ctrl_in`, except that field [31:27] is incremented by one modulo 32. No list register update is issued.
- R6: When an entry matches, `lr_wr_en` pulses and `lr_wr_data` equals that entry with only bit 36 cleared: active-pending becomes pending, and active becomes invalid. No count update is issued.
- R7: When the matched entry has bit 34 set and a physical ID [33:24] below 1020, `phys_deact_valid` pulses with `phys_deact_id` equal to that physical ID. Otherwise no physical request is made.
- R8: Every strobe rises in the cycle after the write strobe is sampled. Each lasts exactly one cycle per accepted write, and all strobes are low in cycles that do not follow a write.
- R9: While `rst_n` is low, all output strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Deactivate-register write strobe |
| wr_data | input | 32 | Written value; ID in [23:0] |
| num_irq | input | 25 | Number of supported interrupt IDs |
| split_mode | input | 1 | Guest EOI-mode split bit |
| lr_flat | input | 48*NUM_LR | Current list register contents, entry i at [48i+47:48i] |
| ctrl_in | input | 32 | Current hypervisor control word |
| lr_wr_en | output | 1 | List register update strobe |
| lr_wr_idx | output | IDX_W | Index of the entry to update |
| lr_wr_data | output | 48 | New entry contents |
| ctrl_wr_en | output | 1 | Control word update strobe |
| ctrl_wr_data | output | 32 | New control word with incremented count |
| phys_deact_valid | output | 1 | Physical deactivate request pulse |
| phys_deact_id | output | 10 | Physical interrupt ID to deactivate |

## Verification
The assertions check on every cycle that a count update and a list register update never happen together. They also check that every strobe follows a write accepted under split mode and an in-range ID, that a physical request only accompanies a list register update with an ID below 1020, that the written entry has its active bit cleared, and that the count field advances by exactly one. Only the bench scenarios can show which entry wins among several candidates and whether the remaining bits of the entry and of the control word are carried through. The bench sweeps every combination of active bits and ID matches over four entries to cover lowest-index selection. It also covers the count wrap from 31 to 0, the boundary at `num_irq`, and the physical ID threshold at 1020.

// File: rtl/vdeact_pkg.sv
// Package: shared field positions for the list register entries and
// the hypervisor control word used by the deactivation unit.
// Assumes a 48-bit list register entry and a 32-bit control word.
package vdeact_pkg;
    localparam int LR_W      = 48;
    localparam int VID_LSB   = 0;
    localparam int VID_W     = 24;
    localparam int PID_LSB   = 24;
    localparam int PID_W     = 10;
    localparam int HW_BIT    = 34;
    localparam int PEND_BIT  = 35;
    localparam int ACT_BIT   = 36;
    localparam int CTRL_W    = 32;
    localparam int CNT_LSB   = 27;
    localparam int CNT_W     = 5;
    localparam int WDATA_W   = 32;
    localparam int NIRQ_W    = VID_W + 1;
    localparam int PID_LIMIT = 1020;
endpackage

// File: rtl/vdeact_gate.sv
// Module: vdeact_gate
// Decides whether a deactivate write is acted on. It extracts the ID
// and qualifies the strobe with the split-mode bit and the range check.
// Assumes num_irq counts valid IDs starting at zero.
module vdeact_gate
    import vdeact_pkg::*;
(
    input  logic               wr_en,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic [NIRQ_W-1:0]  num_irq,
    input  logic               split_mode,
    output logic               go,
    output logic [VID_W-1:0]   id
);
    logic unused_hi;

    // Absorb upper written bits, which carry no meaning here.
    assign unused_hi = ^wr_data[WDATA_W-1:VID_W];

    // Take the ID from the low field and qualify the request.
    always_comb begin
        id = wr_data[VID_W-1:0];
        go = wr_en && split_mode && ({1'b0, id} < num_irq);
    end
endmodule

// File: rtl/vdeact_match.sv
// Module: vdeact_match
// Parallel search of the list registers for an active entry with the
// requested virtual ID. The lowest matching index wins.
// Assumes NUM_LR >= 1. Purely combinational.
module vdeact_match
    import vdeact_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic [NUM_LR*LR_W-1:0] lr_flat,
    input  logic [VID_W-1:0]       id,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx,
    output logic [LR_W-1:0]        entry
);
    logic [LR_W-1:0]   lr_arr [NUM_LR];
    logic [NUM_LR-1:0] cand;

    genvar g;
    generate
        for (g = 0; g < NUM_LR; g++) begin : g_cmp
            // Unpack one entry and flag it when active with the same ID.
            always_comb begin
                lr_arr[g] = lr_flat[g*LR_W +: LR_W];
                cand[g]   = lr_arr[g][ACT_BIT] &&
                            (lr_arr[g][VID_LSB +: VID_W] == id);
            end
        end
    endgenerate

    // Priority pick: scan downward so that the lowest index overwrites.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_LR - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // Select the winning entry contents.
    always_comb entry = lr_arr[idx];
endmodule

// File: rtl/vdeact_eoicnt.sv
// Module: vdeact_eoicnt
// Produces the control word with its end-of-interrupt count field
// advanced by one. The field wraps modulo its width, and all other
// bits are passed through unchanged.
module vdeact_eoicnt
    import vdeact_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [CTRL_W-1:0] ctrl_next
);
    // Rewrite only the count field.
    always_comb begin
        ctrl_next = ctrl_in;
        ctrl_next[CNT_LSB +: CNT_W] = ctrl_in[CNT_LSB +: CNT_W] + CNT_W'(1);
    end
endmodule

// File: rtl/vdeact_unit.sv
// Module: vdeact_unit (top)
// Handles a write to the virtual deactivate register. It either clears
// the active bit of the matching list register entry (with an optional
// physical deactivate) or bumps the EOI count in the control word.
// All results are registered and appear one cycle after wr_en.
// Assumes the consumer applies the update strobes in that cycle.
module vdeact_unit
    import vdeact_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [WDATA_W-1:0]     wr_data,
    input  logic [NIRQ_W-1:0]      num_irq,
    input  logic                   split_mode,
    input  logic [NUM_LR*LR_W-1:0] lr_flat,
    input  logic [CTRL_W-1:0]      ctrl_in,
    output logic                   lr_wr_en,
    output logic [IDX_W-1:0]       lr_wr_idx,
    output logic [LR_W-1:0]        lr_wr_data,
    output logic                   ctrl_wr_en,
    output logic [CTRL_W-1:0]      ctrl_wr_data,
    output logic                   phys_deact_valid,
    output logic [PID_W-1:0]       phys_deact_id
);
    logic              go;
    logic [VID_W-1:0]  id;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [LR_W-1:0]   entry;
    logic [CTRL_W-1:0] ctrl_next;
    logic              phys_ok;
    logic [LR_W-1:0]   cleared;

    vdeact_gate u_gate (
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .num_irq    (num_irq),
        .split_mode (split_mode),
        .go         (go),
        .id         (id)
    );

    vdeact_match #(.NUM_LR(NUM_LR)) u_match (
        .lr_flat (lr_flat),
        .id      (id),
        .hit     (hit),
        .idx     (idx),
        .entry   (entry)
    );

    vdeact_eoicnt u_cnt (
        .ctrl_in   (ctrl_in),
        .ctrl_next (ctrl_next)
    );

    // Decide whether the matched entry links to a physical interrupt.
    always_comb begin
        phys_ok = entry[HW_BIT] &&
                  (int'(entry[PID_LSB +: PID_W]) < PID_LIMIT);
        cleared = entry;
        cleared[ACT_BIT] = 1'b0;
    end

    // Strobe register: one-cycle pulses per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_wr_en         <= 1'b0;
            ctrl_wr_en       <= 1'b0;
            phys_deact_valid <= 1'b0;
        end else begin
            lr_wr_en         <= go && hit;
            ctrl_wr_en       <= go && !hit;
            phys_deact_valid <= go && hit && phys_ok;
        end
    end

    // Payload register: captured only when a write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_wr_idx     <= '0;
            lr_wr_data    <= '0;
            ctrl_wr_data  <= '0;
            phys_deact_id <= '0;
        end else if (go) begin
            lr_wr_idx     <= idx;
            lr_wr_data    <= cleared;
            ctrl_wr_data  <= ctrl_next;
            phys_deact_id <= entry[PID_LSB +: PID_W];
        end
    end
endmodule

// File: rtl/vdeact_unit_chk.sv
// Module: vdeact_unit_chk
// Checker bound into vdeact_unit. It holds cycle-level properties
// relating the update strobes to the write that caused them.
module vdeact_unit_chk
    import vdeact_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [WDATA_W-1:0] wr_data,
    input logic [NIRQ_W-1:0]  num_irq,
    input logic               split_mode,
    input logic [CTRL_W-1:0]  ctrl_in,
    input logic               lr_wr_en,
    input logic [LR_W-1:0]    lr_wr_data,
    input logic               ctrl_wr_en,
    input logic [CTRL_W-1:0]  ctrl_wr_data,
    input logic               phys_deact_valid,
    input logic [PID_W-1:0]   phys_deact_id
);
    assert_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_wr_en || ctrl_wr_en) |-> $past(wr_en));

    assert_split_needed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_wr_en || ctrl_wr_en) |-> $past(split_mode));

    assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_wr_en || ctrl_wr_en) |-> $past({1'b0, wr_data[VID_W-1:0]} < num_irq));

    assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lr_wr_en && ctrl_wr_en));

    assert_active_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lr_wr_en |-> !lr_wr_data[ACT_BIT]);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_en |-> (ctrl_wr_data[CNT_LSB +: CNT_W] ==
                        CNT_W'($past(ctrl_in[CNT_LSB +: CNT_W]) + CNT_W'(1))));

    assert_phys_with_lr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phys_deact_valid |-> (lr_wr_en && (int'(phys_deact_id) < PID_LIMIT)));
endmodule

bind vdeact_unit vdeact_unit_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .wr_data          (wr_data),
    .num_irq          (num_irq),
    .split_mode       (split_mode),
    .ctrl_in          (ctrl_in),
    .lr_wr_en         (lr_wr_en),
    .lr_wr_data       (lr_wr_data),
    .ctrl_wr_en       (ctrl_wr_en),
    .ctrl_wr_data     (ctrl_wr_data),
    .phys_deact_valid (phys_deact_valid),
    .phys_deact_id    (phys_deact_id)
);

// File: tb/vdeact_unit_test.sv
`timescale 1ns/1ps
// Bench for vdeact_unit with four list register entries.
module vdeact_unit_test;
    localparam int NL = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [24:0]       num_irq = 25'd1024;
    logic              split_mode = 1'b1;
    logic [47:0]       lrs [NL];
    logic [NL*48-1:0]  lr_flat;
    logic [31:0]       ctrl_in = 32'h0000_1234;
    logic              lr_wr_en;
    logic [1:0]        lr_wr_idx;
    logic [47:0]       lr_wr_data;
    logic              ctrl_wr_en;
    logic [31:0]       ctrl_wr_data;
    logic              phys_deact_valid;
    logic [9:0]        phys_deact_id;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    assign lr_flat = {lrs[3], lrs[2], lrs[1], lrs[0]};

    vdeact_unit #(.NUM_LR(NL)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .num_irq(num_irq), .split_mode(split_mode), .lr_flat(lr_flat),
        .ctrl_in(ctrl_in), .lr_wr_en(lr_wr_en), .lr_wr_idx(lr_wr_idx),
        .lr_wr_data(lr_wr_data), .ctrl_wr_en(ctrl_wr_en),
        .ctrl_wr_data(ctrl_wr_data), .phys_deact_valid(phys_deact_valid),
        .phys_deact_id(phys_deact_id)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] mk_lr(input logic [23:0] vid, input logic [9:0] pid,
                                          input logic hw, input logic pend, input logic act);
        return {11'h5A3, act, pend, hw, pid, vid};
    endfunction

    // Issue one write and compare all outputs against the requirement model.
    task automatic do_write(input logic [31:0] data, input string tag);
        logic [23:0] id;
        logic go, hit, ph;
        int e_idx;
        logic [47:0] exp_lr;
        id = data[23:0];
        go = split_mode && ({1'b0, id} < num_irq);   // R2 R3
        hit = 1'b0; e_idx = 0;
        for (int i = NL - 1; i >= 0; i--)            // R4 lowest index wins
            if (lrs[i][36] && lrs[i][23:0] == id) begin hit = 1'b1; e_idx = i; end
        exp_lr = lrs[e_idx] & ~(48'h1 << 36);        // R6
        ph = lrs[e_idx][34] && (lrs[e_idx][33:24] < 10'd1020); // R7
        @(negedge clk); wr_data = data; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        chk({tag, " R6 lr_wr_en"}, 64'(lr_wr_en), 64'(go && hit));
        chk({tag, " R5 ctrl_wr_en"}, 64'(ctrl_wr_en), 64'(go && !hit));
        chk({tag, " R7 phys_valid"}, 64'(phys_deact_valid), 64'(go && hit && ph));
        if (go && hit) begin
            chk({tag, " R4 idx"}, 64'(lr_wr_idx), 64'(e_idx));
            chk({tag, " R6 data"}, 64'(lr_wr_data), 64'(exp_lr));
            if (ph) chk({tag, " R7 pid"}, 64'(phys_deact_id), 64'(lrs[e_idx][33:24]));
        end
        if (go && !hit)
            chk({tag, " R5 ctrl"}, 64'(ctrl_wr_data),
                64'({ctrl_in[31:27] + 5'd1, ctrl_in[26:0]}));
        @(negedge clk);
        chk({tag, " R8 idle"}, 64'({lr_wr_en, ctrl_wr_en, phys_deact_valid}), 64'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) lrs[i] = '0;
        repeat (3) @(negedge clk);
        // R9: strobes low during reset
        chk("R9 reset", 64'({lr_wr_en, ctrl_wr_en, phys_deact_valid}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R6 R7 R5: sweep all active and match patterns
        for (int a = 0; a < 16; a++) begin
            for (int m = 0; m < 16; m++) begin
                for (int i = 0; i < NL; i++)
                    lrs[i] = mk_lr(m[i] ? 24'd100 : 24'd101 + 24'(i),
                                   10'd1018 + 10'(i), 1'b1, 1'(i % 2), a[i]);
                ctrl_in = {5'(a + m), 27'h0AB_CDEF};
                do_write(32'd100, "sweep");
            end
        end

        // R1: upper bits ignored
        lrs[0] = mk_lr(24'd7, 10'd33, 1'b1, 1'b1, 1'b1);
        for (int i = 1; i < NL; i++) lrs[i] = '0;
        do_write(32'hFF00_0007, "R1 upper");
        // R7: hw=0 gives no physical request
        lrs[0] = mk_lr(24'd7, 10'd33, 1'b0, 1'b0, 1'b1);
        do_write(32'd7, "R7 nohw");
        // R5: count wraps from 31 to 0
        ctrl_in = 32'hFFFF_FFFF;
        do_write(32'd9, "R5 wrap");
        // R2: boundary at num_irq
        num_irq = 25'd8;
        lrs[0] = mk_lr(24'd7, 10'd5, 1'b1, 1'b0, 1'b1);
        lrs[1] = mk_lr(24'd8, 10'd6, 1'b1, 1'b0, 1'b1);
        do_write(32'd7, "R2 last");
        do_write(32'd8, "R2 equal");
        do_write(32'd1023, "R2 special");
        num_irq = 25'h100_0000;
        do_write(32'h00FF_FFFF, "R2 max");
        // R3: split mode off
        split_mode = 1'b0;
        do_write(32'd7, "R3 off");
        do_write(32'd3, "R3 off nomatch");
        split_mode = 1'b1;
        // R8: back-to-back writes each give one pulse
        @(negedge clk); wr_data = 32'd7; wr_en = 1'b1;
        @(negedge clk); wr_data = 32'd3;
        chk("R8 b2b first", 64'({lr_wr_en, ctrl_wr_en}), 64'(2'b10));
        @(negedge clk); wr_en = 1'b0;
        chk("R8 b2b second", 64'({lr_wr_en, ctrl_wr_en}), 64'(2'b01));
        @(negedge clk);
        chk("R8 b2b idle", 64'({lr_wr_en, ctrl_wr_en, phys_deact_valid}), 64'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule